// File: doc/BRIEF.md
# SPI Master Transfer Timing Sequencer

This block is an SPI master engine that moves one 8-bit or 16-bit word per transfer to one of four peripherals. Each peripheral has its own settings: a clock divisor, a setup delay between chip-select assertion and the first clock edge, a recovery delay between two transfers to the same peripheral, and a word width. The engine picks these settings from the peripheral it is addressing, so traffic to several peripherals at different rates needs no reprogramming between words. A single global gap delay is inserted whenever the addressed peripheral differs from the previous one.

The peripheral comes either from a fixed configuration field (fixed mode) or from a select field carried with each transmit word (variable mode). Words are offered through a valid/ready handshake. The received word is presented with a one-cycle done pulse. A word addressed to a peripheral whose divisor is zero is consumed without starting a transfer, and an error pulse is raised.

The controller is a state machine with six states:
- ST_IDLE waits for a word.
- ST_CS_GAP is the global change delay.
- ST_RECOVER is the same-peripheral recovery delay.
- ST_SETUP holds the select low before clocking.
- ST_SCK_LO and ST_SCK_HI are the two halves of each SPI clock period.

The transitions are:
- ST_IDLE to ST_SETUP on the first word after reset.
- ST_IDLE to ST_RECOVER on a word for the previous peripheral.
- ST_IDLE to ST_CS_GAP on a word for a different peripheral.
- ST_IDLE to ST_IDLE on a word whose divisor is zero.
- ST_CS_GAP or ST_RECOVER to ST_SETUP when their timer expires.
- ST_SETUP to ST_SCK_LO.
- ST_SCK_LO to ST_SCK_HI, sampling MISO.
- ST_SCK_HI to ST_SCK_LO, shifting MOSI.
- ST_SCK_HI to ST_IDLE after the last bit.

Top module: `spi_seq_master`

## Requirements
- R1: After reset, cs_n is 4'b1111, sck is 0, tx_ready is 1, and both rx_done and err_div0 are 0.
- R2: SCK idles low. Each high half and each low half of an SCK period lasts exactly the divisor of the active peripheral, counted in clk cycles.
- R3: A word accepted for a peripheral whose divisor is 0 asserts no chip select. It raises err_div0 for exactly the one cycle after acceptance and leaves the record of the previous peripheral unchanged.
- R4: Each peripheral uses its own divisor, so back-to-back words to different peripherals clock at different rates with no change of configuration.
- R5: When the addressed peripheral differs from the previous one, its chip select falls max(cfg_cs_gap,1) cycles after the acceptance edge.
- R6: For the first word after reset, the chip select falls in the cycle right after acceptance. When the peripheral is the same as the previous one, it falls max(recover,1) cycles after acceptance, using that peripheral's recovery field.
- R7: The first rising SCK edge comes max(setup,1) plus divisor cycles after the chip select falls, using the peripheral's own setup field.
- R8: All chip selects are high outside a transfer and in the rx_done cycle. At most one is low at a time, and the low line never moves straight to another line.
- R9: With cfg_var_sel 0, the peripheral is cfg_fixed_cs and tx_cs is ignored. With cfg_var_sel 1, tx_cs selects the peripheral. Peripheral n drives cs_n[n] low.
- R10: When cfg_wide[n] is 1, transfers to peripheral n have 16 bits. When it is 0, they have 8 bits, send tx_data[7:0], and return the received byte in rx_data[7:0] with rx_data[15:8] zero.
- R11: Data moves MSB first in SPI mode 0. MOSI changes only on falling SCK, and MISO is sampled on rising SCK.
- R12: tx_ready is high only while idle. rx_done is a one-cycle pulse, and rx_data holds the received word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_var_sel | input | 1 | 1: per-word select; 0: fixed select |
| cfg_fixed_cs | input | 2 | Peripheral used in fixed mode |
| cfg_cs_gap | input | 8 | Global delay when the peripheral changes |
| cfg_div | input | 32 | Per-peripheral divisor, 8 bits each, peripheral n at [8n+7:8n] |
| cfg_setup | input | 32 | Per-peripheral setup delay, same packing |
| cfg_recover | input | 32 | Per-peripheral recovery delay, same packing |
| cfg_wide | input | 4 | Per-peripheral 16-bit word enable |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine accepts a word |
| tx_data | input | 16 | Transmit word |
| tx_cs | input | 2 | Per-word peripheral select |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |
| rx_data | output | 16 | Last received word |
| rx_done | output | 1 | Received word valid pulse |
| err_div0 | output | 1 | Word refused because its divisor is zero |

## Verification
The assertions check the chip-select and handshake invariants on every cycle:
- at most one select is low, and a select never hands over directly to another;
- SCK toggles only under an asserted select;
- rx_done is a single cycle with all selects released;
- an error pulse follows an accepted word and never coincides with a select.

Cycle counts need the bench's scenarios, because they depend on per-peripheral configuration and history:
- the gap and recovery lengths, the setup length and the half-period lengths;
- fixed versus variable selection, and the 8-bit and 16-bit data paths;
- the unchanged history after a refused word.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CS_GAP,
        ST_RECOVER,
        ST_SETUP,
        ST_SCK_LO,
        ST_SCK_HI
    } seq_state_e;

endpackage

// File: rtl/spi_cfg_select.sv
module spi_cfg_select #(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 8,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic [CS_W-1:0]         sel,
    input  logic [NUM_CS*CNT_W-1:0] div_all,
    input  logic [NUM_CS*CNT_W-1:0] setup_all,
    input  logic [NUM_CS*CNT_W-1:0] recov_all,
    input  logic [NUM_CS-1:0]       wide_all,
    output logic [CNT_W-1:0]        div,
    output logic [CNT_W-1:0]        setup,
    output logic [CNT_W-1:0]        recov,
    output logic                    wide
);

    logic [CNT_W-1:0] div_a   [NUM_CS];
    logic [CNT_W-1:0] setup_a [NUM_CS];
    logic [CNT_W-1:0] recov_a [NUM_CS];

    // One lane per chip select, unpacked from the flat configuration buses
    for (genvar g = 0; g < NUM_CS; g++) begin : g_lane
        assign div_a[g]   = div_all[g*CNT_W +: CNT_W];
        assign setup_a[g] = setup_all[g*CNT_W +: CNT_W];
        assign recov_a[g] = recov_all[g*CNT_W +: CNT_W];
    end

    assign div   = div_a[sel];
    assign setup = setup_a[sel];
    assign recov = recov_a[sel];
    assign wide  = wide_all[sel];

endmodule

// File: rtl/spi_phase_timer.sv
module spi_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Loaded with (length - 1); counts down to zero and holds there
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
    parameter int DATA_W = 16,
    localparam int HALF  = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              wide,
    input  logic [DATA_W-1:0] data,
    input  logic              shift,
    input  logic              sample,
    input  logic              miso,
    output logic              mosi_bit,
    output logic [DATA_W-1:0] rx_word
);

    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;

    // A narrow word is left-aligned so the MSB always leaves first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
        end else begin
            if (load) begin
                tx_sr <= wide ? data : {data[HALF-1:0], {HALF{1'b0}}};
                rx_sr <= '0;
            end else begin
                if (shift) begin
                    tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                end
                if (sample) begin
                    rx_sr <= {rx_sr[DATA_W-2:0], miso};
                end
            end
        end
    end

    assign mosi_bit = tx_sr[DATA_W-1];
    assign rx_word  = rx_sr;

endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master
    import spi_seq_pkg::*;
#(
    parameter int NUM_CS  = 4,
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 8,
    localparam int CS_W   = $clog2(NUM_CS),
    localparam int BIT_W  = $clog2(DATA_W),
    localparam int HALF   = DATA_W / 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_var_sel,
    input  logic [CS_W-1:0]         cfg_fixed_cs,
    input  logic [CNT_W-1:0]        cfg_cs_gap,
    input  logic [NUM_CS*CNT_W-1:0] cfg_div,
    input  logic [NUM_CS*CNT_W-1:0] cfg_setup,
    input  logic [NUM_CS*CNT_W-1:0] cfg_recover,
    input  logic [NUM_CS-1:0]       cfg_wide,
    input  logic                    tx_valid,
    output logic                    tx_ready,
    input  logic [DATA_W-1:0]       tx_data,
    input  logic [CS_W-1:0]         tx_cs,
    output logic                    sck,
    output logic                    mosi,
    input  logic                    miso,
    output logic [NUM_CS-1:0]       cs_n,
    output logic [DATA_W-1:0]       rx_data,
    output logic                    rx_done,
    output logic                    err_div0
);

    seq_state_e       state, nxt_state;
    logic [CS_W-1:0]  tgt_cs, cur_cs, last_cs, cfg_idx;
    logic             hist_valid, cur_wide;
    logic [BIT_W-1:0] bit_cnt, last_bit;
    logic [CNT_W-1:0] sel_div, sel_setup, sel_recov;
    logic             sel_wide;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             start, do_shift, do_sample, xfer_end;
    logic             mosi_bit, active;
    logic [DATA_W-1:0] rx_word;

    // A programmed delay of zero still lasts one cycle
    function automatic logic [CNT_W-1:0] span_load(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    assign tgt_cs   = cfg_var_sel ? tx_cs : cfg_fixed_cs;
    assign cfg_idx  = (state == ST_IDLE) ? tgt_cs : cur_cs;
    assign last_bit = cur_wide ? BIT_W'(DATA_W - 1) : BIT_W'(HALF - 1);

    spi_cfg_select #(.NUM_CS(NUM_CS), .CNT_W(CNT_W)) u_cfg (
        .sel       (cfg_idx),
        .div_all   (cfg_div),
        .setup_all (cfg_setup),
        .recov_all (cfg_recover),
        .wide_all  (cfg_wide),
        .div       (sel_div),
        .setup     (sel_setup),
        .recov     (sel_recov),
        .wide      (sel_wide)
    );

    spi_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    spi_shift_unit #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .wide     (sel_wide),
        .data     (tx_data),
        .shift    (do_shift),
        .sample   (do_sample),
        .miso     (miso),
        .mosi_bit (mosi_bit),
        .rx_word  (rx_word)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt_state;
        end
    end

    // Transition logic and timer programming
    always_comb begin
        nxt_state = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        start     = 1'b0;
        do_shift  = 1'b0;
        do_sample = 1'b0;
        xfer_end  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (tx_valid && (sel_div != '0)) begin
                    start    = 1'b1;
                    tmr_load = 1'b1;
                    if (!hist_valid) begin
                        nxt_state = ST_SETUP;
                        tmr_val   = span_load(sel_setup);
                    end else if (tgt_cs == last_cs) begin
                        nxt_state = ST_RECOVER;
                        tmr_val   = span_load(sel_recov);
                    end else begin
                        nxt_state = ST_CS_GAP;
                        tmr_val   = span_load(cfg_cs_gap);
                    end
                end
            end
            ST_CS_GAP, ST_RECOVER: begin
                if (tmr_expired) begin
                    nxt_state = ST_SETUP;
                    tmr_load  = 1'b1;
                    tmr_val   = span_load(sel_setup);
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    nxt_state = ST_SCK_LO;
                    tmr_load  = 1'b1;
                    tmr_val   = span_load(sel_div);
                end
            end
            ST_SCK_LO: begin
                if (tmr_expired) begin
                    nxt_state = ST_SCK_HI;
                    tmr_load  = 1'b1;
                    tmr_val   = span_load(sel_div);
                    do_sample = 1'b1;
                end
            end
            ST_SCK_HI: begin
                if (tmr_expired) begin
                    if (bit_cnt == last_bit) begin
                        nxt_state = ST_IDLE;
                        xfer_end  = 1'b1;
                    end else begin
                        nxt_state = ST_SCK_LO;
                        tmr_load  = 1'b1;
                        tmr_val   = span_load(sel_div);
                        do_shift  = 1'b1;
                    end
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // Transfer bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_cs     <= '0;
            last_cs    <= '0;
            hist_valid <= 1'b0;
            cur_wide   <= 1'b0;
            bit_cnt    <= '0;
            rx_data    <= '0;
            rx_done    <= 1'b0;
            err_div0   <= 1'b0;
        end else begin
            rx_done  <= xfer_end;
            err_div0 <= (state == ST_IDLE) && tx_valid && (sel_div == '0);
            if (start) begin
                cur_cs     <= tgt_cs;
                last_cs    <= tgt_cs;
                hist_valid <= 1'b1;
                cur_wide   <= sel_wide;
                bit_cnt    <= '0;
            end else if (do_shift) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (xfer_end) begin
                rx_data <= rx_word;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        active   = (state == ST_SETUP) || (state == ST_SCK_LO) || (state == ST_SCK_HI);
        tx_ready = (state == ST_IDLE);
        sck      = (state == ST_SCK_HI);
        mosi     = active && mosi_bit;
        cs_n     = '1;
        if (active) begin
            cs_n[cur_cs] = 1'b0;
        end
    end

endmodule

// File: rtl/spi_seq_checker.sv
module spi_seq_checker #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              sck,
    input logic [NUM_CS-1:0] cs_n,
    input logic              rx_done,
    input logic              err_div0
);

    // R8: never more than one peripheral selected
    a_r8_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    // R8: a low select may only stay on the same line or release
    a_r8_no_direct_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && !(&$past(cs_n))) |-> (cs_n == $past(cs_n)));

    // R2: clock pulses only inside a selected transfer
    a_r2_sck_under_select: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !(&cs_n));

    // R12: completion is a single-cycle pulse
    a_r12_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done);

    // R8, R12: completion arrives with all selects released and ready high
    a_r12_done_released: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> ((&cs_n) && tx_ready));

    // R12: ready only while the bus is quiet
    a_r12_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> ((&cs_n) && !sck));

    // R3: a refused word selects nothing
    a_r3_err_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        err_div0 |-> (&cs_n));

    // R3: the error follows an accepted word
    a_r3_err_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        err_div0 |-> $past(tx_valid && tx_ready));

endmodule

bind spi_seq_master spi_seq_checker #(.NUM_CS(NUM_CS)) u_seq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .sck      (sck),
    .cs_n     (cs_n),
    .rx_done  (rx_done),
    .err_div0 (err_div0)
);

// File: tb/spi_seq_master_test.sv
module spi_seq_master_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_var_sel = 1'b1;
    logic [1:0]  cfg_fixed_cs = 2'd1;
    logic [7:0]  cfg_cs_gap = 8'd3;
    logic [31:0] cfg_div, cfg_setup, cfg_recover;
    logic [3:0]  cfg_wide = 4'b1010;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic [15:0] tx_data = '0;
    logic [1:0]  tx_cs = '0;
    logic        sck, mosi, miso;
    logic [3:0]  cs_n;
    logic [15:0] rx_data;
    logic        rx_done, err_div0;

    logic [7:0] b_div   [4] = '{8'd1, 8'd3, 8'd2, 8'd0};
    logic [7:0] b_setup [4] = '{8'd0, 8'd4, 8'd1, 8'd0};
    logic [7:0] b_recov [4] = '{8'd2, 8'd0, 8'd5, 8'd1};

    assign cfg_div     = {b_div[3], b_div[2], b_div[1], b_div[0]};
    assign cfg_setup   = {b_setup[3], b_setup[2], b_setup[1], b_setup[0]};
    assign cfg_recover = {b_recov[3], b_recov[2], b_recov[1], b_recov[0]};

    int checks = 0;
    int failures = 0;
    int prev_cs = -1;

    always #5 clk = ~clk;

    spi_seq_master uut (
        .clk(clk), .rst_n(rst_n), .cfg_var_sel(cfg_var_sel), .cfg_fixed_cs(cfg_fixed_cs),
        .cfg_cs_gap(cfg_cs_gap), .cfg_div(cfg_div), .cfg_setup(cfg_setup),
        .cfg_recover(cfg_recover), .cfg_wide(cfg_wide), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_cs(tx_cs), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n), .rx_data(rx_data), .rx_done(rx_done), .err_div0(err_div0)
    );

    // Slave model: loads its pattern when any select falls, shifts on falling SCK
    logic [15:0] slv_pat = '0, slv_sr = '0, cap = '0;
    logic        slv_wide = 1'b0;
    int          nbits = 0;
    wire         any_sel = ~&cs_n;

    assign miso = slv_sr[15];

    always @(posedge any_sel) begin
        slv_sr = slv_wide ? slv_pat : {slv_pat[7:0], 8'h00};
        cap    = '0;
        nbits  = 0;
    end
    always @(negedge sck) slv_sr = {slv_sr[14:0], 1'b0};
    always @(posedge sck) begin
        cap   = {cap[14:0], mosi};
        nbits = nbits + 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int min1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic xfer(input logic vm, input logic [1:0] tcs, input logic [15:0] data,
                        input logic [15:0] pat);
        int ecs, d, pre, n, s, h;
        logic w;
        logic [3:0] esel;
        string preq;
        ecs = vm ? int'(tcs) : int'(cfg_fixed_cs);
        d   = int'(b_div[ecs]);
        w   = cfg_wide[ecs];
        if (prev_cs < 0) begin pre = 0; preq = "R6"; end
        else if (prev_cs == ecs) begin pre = min1(int'(b_recov[ecs])); preq = "R6"; end
        else begin pre = min1(int'(cfg_cs_gap)); preq = "R5"; end
        slv_pat  = pat;
        slv_wide = w;
        @(negedge clk);
        cfg_var_sel = vm; tx_cs = tcs; tx_data = data; tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        if (d == 0) begin
            chk("R3", "error pulse", int'(err_div0), 1);
            chk("R3", "no select on refused word", int'(cs_n), 'hF);
            @(negedge clk);
            chk("R3", "error pulse ends", int'(err_div0), 0);
            chk("R3", "still idle after refusal", int'({cs_n, tx_ready}), 'h1F);
            return;
        end
        n = 0;
        while (&cs_n) begin n++; @(negedge clk); end
        chk(preq, "cycles before select", n, pre);
        esel = 4'hF;
        esel[ecs] = 1'b0;
        chk("R9", "selected line", int'(cs_n), int'(esel));
        s = 0;
        while (!sck) begin s++; @(negedge clk); end
        chk("R7", "select to first rise", s, min1(int'(b_setup[ecs])) + d);
        h = 0;
        while (sck) begin h++; @(negedge clk); end
        chk("R2/R4", "high half length", h, d);
        while (!rx_done) @(negedge clk);
        chk("R10", "received word", int'(rx_data), w ? int'(pat) : int'(pat[7:0]));
        chk("R11", "bits seen by slave", int'(cap), w ? int'(data) : int'(data[7:0]));
        chk("R10", "bit count", nbits, w ? 16 : 8);
        chk("R8", "selects released at done", int'(cs_n), 'hF);
        chk("R12", "ready at done", int'(tx_ready), 1);
        @(negedge clk);
        chk("R12", "done is one cycle", int'(rx_done), 0);
        prev_cs = ecs;
    endtask

    // {variable mode, tx_cs, tx_data, slave pattern}
    localparam logic [34:0] VEC [8] = '{
        {1'b1, 2'd0, 16'h00A5, 16'h003C},
        {1'b1, 2'd0, 16'h005A, 16'h00C3},
        {1'b1, 2'd1, 16'hBEEF, 16'h1234},
        {1'b1, 2'd1, 16'h8001, 16'hFFFF},
        {1'b1, 2'd2, 16'h77FF, 16'h5581},
        {1'b0, 2'd2, 16'h1357, 16'h2468},
        {1'b0, 2'd0, 16'h0F0F, 16'hF0F0},
        {1'b1, 2'd0, 16'h0080, 16'h0001}
    };

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset cs_n", int'(cs_n), 'hF);
        chk("R1", "reset sck", int'(sck), 0);
        chk("R1", "reset ready", int'(tx_ready), 1);
        chk("R1", "reset done/err", int'({rx_done, err_div0}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after release", int'({cs_n, sck}), 'h1E);

        for (int i = 0; i < 8; i++) begin
            xfer(VEC[i][34], VEC[i][33:32], VEC[i][31:16], VEC[i][15:0]);
        end

        // R3: zero divisor refused; history stays on peripheral 0
        xfer(1'b1, 2'd3, 16'hAAAA, 16'h5555);
        b_div[3] = 8'd2;
        xfer(1'b1, 2'd3, 16'hC3A5, 16'h9966);   // R5: gap from 0 to 3
        // R5: zero gap still costs one cycle
        cfg_cs_gap = 8'd0;
        xfer(1'b1, 2'd0, 16'h0042, 16'h0024);
        // R4, R7: new rate and setup on the same peripheral
        b_div[0] = 8'd5;
        b_setup[0] = 8'd6;
        xfer(1'b1, 2'd0, 16'h00E1, 16'h001E);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule